// File: doc/BRIEF.md
# Local Trigger and Reset Command Generator

This block sits in a crate controller and produces the trigger strobes and reset pulses that the rest of the crate needs. For bench work it turns three debounced front-panel switch levels into a single-shot trigger, a free-running trigger train or a reset of the clock manager. In normal running it decodes the fast-control command byte stream: one code is stretched into a fixed-length hard-reset pulse for the downstream boards, and another becomes a one-cycle sync-reset strobe.

The same command stream is forwarded downstream. While the external fast-control link reports itself present, its bytes are forwarded. When the link is absent, the block falls back to bytes written into a local register port. The decoder always works on the forwarded stream. The hard-reset pulse only drives the downstream output and never clears this block's own counters. Switch debouncing, optical reception and line drivers sit outside the block.

Top module: `trg_reset_gen`

## Requirements
- R1: While the synchronous active-high `rst` is asserted, and in the cycle after its release, every output is low. This includes the forwarded command, which is all zeros.
- R2: A low-to-high change of `sw_single` produces exactly one `l1a_o` strobe, one cycle wide, in the cycle after the change is sampled. The exception is when all three switches are high.
- R3: Holding `sw_single` high produces no further strobes beyond the one from R2.
- R4: While `sw_run_a` and `sw_run_b` are high and `sw_single` is low, `l1a_o` pulses for one cycle every PERIOD_CYCLES cycles. The first pulse comes PERIOD_CYCLES cycles after the first sampled enabled cycle. Leaving this condition restarts the count. PERIOD_CYCLES is the ceiling of CLK_HZ·PERIOD_NS/1e9, which is 125000 at the defaults.
- R5: While all three switches are high, `cm_reset_o` is high, one cycle after sampling, and `l1a_o` stays low.
- R6: A valid forwarded command of code 0x04 drives `hard_rst_o` high for exactly PULSE_CYCLES consecutive cycles, starting the next cycle. PULSE_CYCLES is the ceiling of CLK_HZ·PULSE_NS/1e9, which is 32 at the defaults.
- R7: A code 0x04 that arrives while the pulse is high restarts the full PULSE_CYCLES count from that command.
- R8: The hard-reset command leaves the trigger generator untouched: the free-running period and phase continue unchanged across it.
- R9: A valid forwarded command of code 0x03 gives one `sync_rst_o` strobe in the next cycle. Other codes give neither reset output.
- R10: When `fc_link_ok` is high, `fwd_valid_o`/`fwd_cmd_o` repeat `fc_valid`/`fc_cmd` one cycle later. When it is low, they repeat `loc_valid`/`loc_cmd` instead. The R6 and R9 decoding applies only to the selected stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_single | input | 1 | Debounced switch 1 level |
| sw_run_a | input | 1 | Debounced switch 2 level |
| sw_run_b | input | 1 | Debounced switch 3 level |
| fc_link_ok | input | 1 | External fast-control link present |
| fc_valid | input | 1 | External command byte valid |
| fc_cmd | input | 8 | External command byte |
| loc_valid | input | 1 | Locally written command valid |
| loc_cmd | input | 8 | Locally written command byte |
| l1a_o | output | 1 | Trigger strobe |
| cm_reset_o | output | 1 | Clock-manager reset |
| hard_rst_o | output | 1 | Stretched downstream hard-reset pulse |
| sync_rst_o | output | 1 | Sync-reset strobe |
| fwd_valid_o | output | 1 | Forwarded command valid |
| fwd_cmd_o | output | 8 | Forwarded command byte |

## Verification
The free-running trigger and the hard-reset stretcher are independent, so a 0x04 command can land in the same cycle as a periodic trigger. The bench does this on purpose by issuing the command partway through a free-running train, and then checks two things: the gap between triggers still equals the period, and the pulse width still equals its nominal length. A second coincidence is a repeat 0x04 that arrives while the pulse is still high. The bench provokes this a few cycles into a pulse and expects the total width to be the offset plus the full length. A cycle-by-cycle reference model also checks both outputs under random switch and command traffic.

// File: rtl/trg_pkg.sv
package trg_pkg;
   parameter int CMD_W = 8;
   typedef logic [CMD_W-1:0] cmd_code_t;
   typedef struct packed {
      logic      valid;
      cmd_code_t code;
   } cmd_beat_t;

   function automatic int ns_to_cycles(longint unsigned clk_hz, longint unsigned ns);
      return int'((clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction
endpackage

// File: rtl/trg_l1a_src.sv
module trg_l1a_src #(
   parameter int PERIOD_CYCLES = 125000
) (
   input  logic clk,
   input  logic rst,
   input  logic sw_single,
   input  logic sw_run_a,
   input  logic sw_run_b,
   output logic l1a,
   output logic cm_reset
);
   localparam int PW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
   localparam logic [PW-1:0] LAST = PW'(PERIOD_CYCLES - 1);

   logic          single_q;
   logic [PW-1:0] run_cnt;
   logic          all_hi, run_en, single_hit, tick;

   assign all_hi     = sw_single & sw_run_a & sw_run_b;
   assign run_en     = sw_run_a & sw_run_b & ~sw_single;
   assign single_hit = sw_single & ~single_q & ~all_hi;
   assign tick       = run_en && (run_cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         single_q <= 1'b0;
         run_cnt  <= '0;
         l1a      <= 1'b0;
         cm_reset <= 1'b0;
      end else begin
         single_q <= sw_single;
         if (!run_en || tick) run_cnt <= '0;
         else                 run_cnt <= run_cnt + 1'b1;
         l1a      <= single_hit | tick;
         cm_reset <= all_hi;
      end
   end

   // R5: the clock-manager reset condition never coexists with a trigger
   assert_no_l1a_in_cm_reset_R5: assert property (@(posedge clk) disable iff (rst)
      cm_reset |-> !l1a);

   // R2 / R4: a trigger needs a prior single switch or run enable
   assert_l1a_has_source_R4: assert property (@(posedge clk) disable iff (rst)
      l1a |-> $past(sw_single || (sw_run_a && sw_run_b)));
endmodule

// File: rtl/trg_cmd_path.sv
module trg_cmd_path
   import trg_pkg::*;
#(
   parameter cmd_code_t HARD_CODE = 8'h04,
   parameter cmd_code_t SYNC_CODE = 8'h03
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      link_ok,
   input  cmd_beat_t ext_in,
   input  cmd_beat_t loc_in,
   output cmd_beat_t fwd,
   output logic      hard_hit,
   output logic      sync_rst
);
   cmd_beat_t sel;

   assign sel      = link_ok ? ext_in : loc_in;
   assign hard_hit = sel.valid && (sel.code == HARD_CODE);

   always_ff @(posedge clk) begin
      if (rst) begin
         fwd      <= '0;
         sync_rst <= 1'b0;
      end else begin
         fwd      <= sel;
         sync_rst <= sel.valid && (sel.code == SYNC_CODE);
      end
   end

   // R9: the sync strobe matches the forwarded byte
   assert_sync_matches_fwd_R9: assert property (@(posedge clk) disable iff (rst)
      sync_rst |-> (fwd.valid && fwd.code == SYNC_CODE));

   // R10: the forwarded byte comes from the stream selected a cycle earlier
   assert_fwd_source_R10: assert property (@(posedge clk) disable iff (rst)
      fwd.valid |-> (fwd.code == ($past(link_ok) ? $past(ext_in.code) : $past(loc_in.code))));
endmodule

// File: rtl/trg_stretch.sv
module trg_stretch #(
   parameter int LEN = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic trig,
   output logic pulse
);
   generate
      if (LEN == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (rst) pulse <= 1'b0;
            else     pulse <= trig;
         end
      end else begin : g_count
         localparam int CW = $clog2(LEN + 1);
         logic [CW-1:0] left;
         always_ff @(posedge clk) begin
            if (rst)              left <= '0;
            else if (trig)        left <= CW'(LEN);
            else if (left != '0)  left <= left - 1'b1;
         end
         assign pulse = (left != '0);
      end
   endgenerate

   // R6: the pulse only starts after a command
   assert_rise_after_cmd_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse) |-> $past(trig));

   // R7: a command in the previous cycle keeps the pulse from ending
   assert_no_fall_on_retrig_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(pulse) |-> !$past(trig));
endmodule

// File: rtl/trg_reset_gen.sv
module trg_reset_gen
   import trg_pkg::*;
#(
   parameter longint unsigned CLK_HZ    = 64'd78_125_000,
   parameter longint unsigned PERIOD_NS = 64'd1_600_000,
   parameter longint unsigned PULSE_NS  = 64'd400,
   parameter cmd_code_t       HARD_CODE = 8'h04,
   parameter cmd_code_t       SYNC_CODE = 8'h03
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sw_single,
   input  logic             sw_run_a,
   input  logic             sw_run_b,
   input  logic             fc_link_ok,
   input  logic             fc_valid,
   input  logic [CMD_W-1:0] fc_cmd,
   input  logic             loc_valid,
   input  logic [CMD_W-1:0] loc_cmd,
   output logic             l1a_o,
   output logic             cm_reset_o,
   output logic             hard_rst_o,
   output logic             sync_rst_o,
   output logic             fwd_valid_o,
   output logic [CMD_W-1:0] fwd_cmd_o
);
   localparam int PERIOD_CYCLES = ns_to_cycles(CLK_HZ, PERIOD_NS);
   localparam int PULSE_CYCLES  = ns_to_cycles(CLK_HZ, PULSE_NS);

   generate
      if (PERIOD_CYCLES < 2) begin : g_bad_period
         $error("trigger period must be at least two cycles");
      end
      if (PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("hard-reset pulse must be at least one cycle");
      end
      if (HARD_CODE == SYNC_CODE) begin : g_bad_codes
         $error("hard and sync command codes must differ");
      end
   endgenerate

   cmd_beat_t ext_b, loc_b, fwd_b;
   logic      hard_hit;

   assign ext_b = '{valid: fc_valid,  code: fc_cmd};
   assign loc_b = '{valid: loc_valid, code: loc_cmd};

   trg_l1a_src #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_l1a (
      .clk(clk), .rst(rst),
      .sw_single(sw_single), .sw_run_a(sw_run_a), .sw_run_b(sw_run_b),
      .l1a(l1a_o), .cm_reset(cm_reset_o)
   );

   trg_cmd_path #(.HARD_CODE(HARD_CODE), .SYNC_CODE(SYNC_CODE)) u_cmd (
      .clk(clk), .rst(rst), .link_ok(fc_link_ok),
      .ext_in(ext_b), .loc_in(loc_b), .fwd(fwd_b),
      .hard_hit(hard_hit), .sync_rst(sync_rst_o)
   );

   trg_stretch #(.LEN(PULSE_CYCLES)) u_hr (
      .clk(clk), .rst(rst), .trig(hard_hit), .pulse(hard_rst_o)
   );

   assign fwd_valid_o = fwd_b.valid;
   assign fwd_cmd_o   = fwd_b.code;

   // R6: a rising hard reset lines up with a forwarded hard command
   assert_hard_rise_cmd_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(hard_rst_o) |-> (fwd_valid_o && fwd_cmd_o == HARD_CODE));

   // R9: the two resets are never started by the same byte
   assert_sync_not_hard_R9: assert property (@(posedge clk) disable iff (rst)
      sync_rst_o |-> !(fwd_cmd_o == HARD_CODE));
endmodule

// File: tb/sim_trg_reset_gen.sv
module sim_trg_reset_gen;
   localparam int P = 40;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic s1 = 0, s2 = 0, s3 = 0, link = 1, fcv = 0, lv = 0;
   logic [7:0] fc = 0, lc = 0;
   logic l1a, cmr, hr, sr, fv;
   logic [7:0] fcmd;

   int tests = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   trg_reset_gen #(.CLK_HZ(64'd100_000_000), .PERIOD_NS(64'd400), .PULSE_NS(64'd80)) u0 (
      .clk(clk), .rst(rst), .sw_single(s1), .sw_run_a(s2), .sw_run_b(s3),
      .fc_link_ok(link), .fc_valid(fcv), .fc_cmd(fc), .loc_valid(lv), .loc_cmd(lc),
      .l1a_o(l1a), .cm_reset_o(cmr), .hard_rst_o(hr), .sync_rst_o(sr),
      .fwd_valid_o(fv), .fwd_cmd_o(fcmd)
   );

   // reference model built from the requirements
   logic e_l1a = 0, e_cm = 0, e_sr = 0, e_fv = 0, prev_s1 = 0;
   logic [7:0] e_fc = 0;
   int run_cnt = 0, hr_left = 0;

   always @(posedge clk) begin
      if (rst) begin
         e_l1a = 0; e_cm = 0; e_sr = 0; e_fv = 0; e_fc = 0;
         prev_s1 = 0; run_cnt = 0; hr_left = 0;
      end else begin
         logic tick, selv;
         logic [7:0] selc;
         tick = 0;
         if (s2 && s3 && !s1) begin
            if (run_cnt == P - 1) begin run_cnt = 0; tick = 1; end
            else run_cnt++;
         end else run_cnt = 0;
         e_l1a = (s1 && !prev_s1 && !(s1 && s2 && s3)) || tick;
         prev_s1 = s1;
         e_cm = s1 && s2 && s3;
         selv = link ? fcv : lv;
         selc = link ? fc : lc;
         e_fv = selv; e_fc = selc;
         e_sr = selv && selc == 8'h03;
         if (selv && selc == 8'h04) hr_left = H;
         else if (hr_left > 0) hr_left--;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison and event counters
   int n_l1a = 0, n_hr = 0, n_sr = 0, last_l1a = -1, gap = -1, cyc = 0;
   bit model_on = 0;
   always @(negedge clk) begin
      cyc++;
      if (l1a) begin
         n_l1a++;
         if (last_l1a >= 0) gap = cyc - last_l1a;
         last_l1a = cyc;
      end
      if (hr) n_hr++;
      if (sr) n_sr++;
      if (model_on) begin
         chk("R2/R4 l1a model", l1a, e_l1a);
         chk("R5 cm_reset model", cmr, e_cm);
         chk("R6/R7 hard_rst model", hr, hr_left > 0);
         chk("R9 sync_rst model", sr, e_sr);
         chk("R10 fwd_valid model", fv, e_fv);
         chk("R10 fwd_cmd model", fcmd, e_fc);
      end
   end

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic send_ext(input logic [7:0] c);
      fc = c; fcv = 1; step(1); fcv = 0;
   endtask

   task automatic send_loc(input logic [7:0] c);
      lc = c; lv = 1; step(1); lv = 0;
   endtask

   task automatic clr_counts();
      n_l1a = 0; n_hr = 0; n_sr = 0; last_l1a = -1; gap = -1;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      void'($urandom(32'd1234));
      step(3);
      @(negedge clk);
      chk("R1 reset l1a", l1a, 0);
      chk("R1 reset cm_reset", cmr, 0);
      chk("R1 reset hard_rst", hr, 0);
      chk("R1 reset sync_rst", sr, 0);
      chk("R1 reset fwd", {fv, fcmd}, 0);
      step(1);
      rst = 0;
      model_on = 1;
      step(2);

      // R2, R3: one strobe for a held switch
      clr_counts();
      s1 = 1; step(20);
      chk("R2 single shot count", n_l1a, 1);
      chk("R3 held switch no repeat", n_l1a, 1);
      s1 = 0; step(3);

      // R4, R8: free-running train with a hard reset mid-train
      clr_counts();
      s2 = 1; s3 = 1;
      step(P + 10);
      send_ext(8'h04);
      step(2 * P - 12);
      step(5);
      chk("R4 free-run count", n_l1a, 3);
      chk("R4 free-run period", gap, P);
      chk("R8 period kept across hard reset", gap, P);
      chk("R6 hard width during run", n_hr, H);
      s2 = 0; s3 = 0; step(3);

      // R5: all switches high
      clr_counts();
      s2 = 1; s3 = 1; s1 = 1; step(1);
      s1 = 1; step(P + 5);
      @(negedge clk);
      chk("R5 cm_reset high", cmr, 1);
      chk("R5 no l1a", n_l1a, 0);
      s1 = 0; s2 = 0; s3 = 0; step(3);

      // R7: retrigger restarts count
      clr_counts();
      send_ext(8'h04); step(4);
      send_ext(8'h04); step(H + 4);
      chk("R7 retrigger width", n_hr, 5 + H);

      // R9: sync strobe, and a neutral code
      clr_counts();
      send_ext(8'h03); send_ext(8'h55); step(3);
      chk("R9 sync count", n_sr, 1);
      chk("R9 other code no hard", n_hr, 0);

      // R10: link absent selects local stream
      clr_counts();
      link = 0;
      send_ext(8'h03); step(2);
      chk("R10 external ignored without link", n_sr, 0);
      send_loc(8'h03); send_loc(8'h04); step(H + 3);
      chk("R10 local sync used", n_sr, 1);
      chk("R10 local hard used", n_hr, H);
      link = 1;
      send_loc(8'h03); step(2);
      chk("R10 local ignored with link", n_sr, 1);

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         int r;
         if (i % 60 == 0) begin
            r = $urandom_range(0, 7);
            s1 = r[0]; s2 = r[1]; s3 = r[2];
            if (($urandom_range(0, 3)) == 0) s1 = ~s1;
         end
         if ($urandom_range(0, 199) == 0) link = ~link;
         r = $urandom_range(0, 9);
         fcv = ($urandom_range(0, 3) == 0);
         fc  = (r < 3) ? 8'h04 : (r < 6) ? 8'h03 : 8'($urandom);
         lv  = ($urandom_range(0, 3) == 0);
         r = $urandom_range(0, 9);
         lc  = (r < 3) ? 8'h04 : (r < 6) ? 8'h03 : 8'($urandom);
         step(1);
      end
      fcv = 0; lv = 0; s1 = 0; s2 = 0; s3 = 0;
      step(H + 2);
      model_on = 0;
      done = 1;
      summary();
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end
endmodule